// File: doc/BRIEF.md
# Configuration Status Register with Error Capture

This block holds the 16-bit status word of a DMA function attached over PCI Express. The inbound and outbound datapaths report error events as one-cycle strobes. The block latches each event into a sticky bit that stays set until software clears it by writing a one. A small checker looks at every received request, using its kind (memory or configuration), start address and byte length. It raises the target-abort bit when the request is too long for its kind or runs past an aligned unit.

Software reaches the register through a simple configuration port. The port takes a dword address, byte enables, a write strobe and a read strobe. The status word lives at byte offset 0x6, which is the upper half of dword 0x4. All other fields are fixed values, and writes do not change them.

Top module: `cfg_status_unit`

## Requirements
- R1: After reset, a read of dword 0x4 returns 0x0010 in bits 31:16, and the only bit set is the capabilities bit (status bit 4).
- R2: Status bit 15 sets when an event arrives on strobe 0 (uncorrectable data error on the primary side) or on strobe 1 (uncorrectable address/control parity error on the primary side). The parity-response enable makes no difference to this bit.
- R3: Status bit 8 sets on strobe 2 (poisoned completion received from the internal bus) or strobe 3 (poisoned data packet, including a message-signalled interrupt write, forwarded to the internal bus), but only while the parity-response enable is 1.
- R4: Status bit 11 sets when a memory request with nonzero length is longer than 8 bytes, or when (start address mod 8) + length exceeds 8. A zero-length request never sets it.
- R5: Status bit 11 also sets when a configuration request with nonzero length is longer than 4 bytes, or when (start address mod 4) + length exceeds 4.
- R6: A write to bits 15, 11 or 8 with a 1 clears that bit. A write with a 0 leaves the bit unchanged.
- R7: When a set event and a clearing write reach the same bit in the same cycle, the bit ends up set.
- R8: Writes honour byte enables. The status word's upper byte (bits 15:8) is byte lane 3 of the dword, so clearing bits 15, 11 or 8 needs byte enable 3. A write that enables only lane 2 clears nothing.
- R9: Bits 14:12, 10:9, 7:5 and 3:0 always read 0, and bit 4 always reads 1. Writes have no effect on any of them.
- R10: A read strobe to dword 0x4 returns the status word in bits 31:16 on the clock after the strobe. A read of any other dword returns 0. Writes to any other dword do not change the status word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| err_ev_i | input | 4 | Error event strobes: 0 rx data error, 1 rx address/control parity, 2 poisoned completion in, 3 poisoned forward out |
| perr_resp_en_i | input | 1 | Parity-response enable from the command register |
| req_vld_i | input | 1 | Request descriptor valid |
| req_is_cfg_i | input | 1 | 1 for a configuration request, 0 for a memory request |
| req_addr_i | input | 16 | Request start byte address |
| req_len_i | input | 12 | Request length in bytes |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_rd_i | input | 1 | Configuration read strobe |
| cfg_addr_i | input | 12 | Configuration byte address (bits 1:0 ignored) |
| cfg_be_i | input | 4 | Write byte enables |
| cfg_wdata_i | input | 32 | Write data |
| cfg_rdata_o | output | 32 | Read data, valid the clock after a read strobe |

## Verification
The embedded assertions check four things on every cycle. A set request always leaves its sticky bit set on the next clock. A clear without a set always empties the bit. Bit 8 cannot rise while the parity-response enable is low. Every read of the status dword shows the fixed field values. Only the bench scenarios can show the full boundary arithmetic of the size checker, including lengths of exactly one unit, odd offsets and zero length. They also cover clearing with different byte-enable combinations and the absence of any effect from writes to other addresses.

// File: rtl/cfg_status_pkg.sv
package cfg_status_pkg;
   localparam int unsigned STS_W       = 16;
   localparam int unsigned DW_W        = 32;
   localparam int unsigned BE_W        = DW_W / 8;
   localparam int unsigned STS_OFFSET  = 6;
   localparam int unsigned STS_LANE    = STS_OFFSET % BE_W;
   localparam int unsigned N_STICKY    = 3;
   localparam int unsigned N_EV        = 4;

   localparam logic [STS_W-1:0] FIXED_MASK  = 16'h76FF;
   localparam logic [STS_W-1:0] FIXED_VALUE = 16'h0010;

   typedef enum int unsigned {
      EV_RX_DATA   = 0,
      EV_RX_ADDR   = 1,
      EV_POIS_CPL  = 2,
      EV_POIS_FWD  = 3
   } ev_idx_e;

   typedef enum int unsigned {
      SK_MDPE = 0,
      SK_STA  = 1,
      SK_DPE  = 2
   } sticky_idx_e;

   function automatic int unsigned sticky_pos(input int unsigned idx);
      case (idx)
         0:       return 8;
         1:       return 11;
         default: return 15;
      endcase
   endfunction
endpackage

// File: rtl/sts_req_checker.sv
module sts_req_checker #(
   parameter int unsigned ADDR_W   = 16,
   parameter int unsigned LEN_W    = 12,
   parameter int unsigned MEM_UNIT = 8,
   parameter int unsigned CFG_UNIT = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              vld_i,
   input  logic              is_cfg_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [LEN_W-1:0]  len_i,
   output logic              abort_o
);
   localparam int unsigned SUM_W = LEN_W + 1;

   if ((MEM_UNIT & (MEM_UNIT - 1)) != 0 || MEM_UNIT == 0) begin : g_bad_mem
      $error("MEM_UNIT must be a power of two");
   end
   if ((CFG_UNIT & (CFG_UNIT - 1)) != 0 || CFG_UNIT == 0) begin : g_bad_cfg
      $error("CFG_UNIT must be a power of two");
   end
   if (MEM_UNIT >= (1 << LEN_W) || CFG_UNIT >= (1 << LEN_W)) begin : g_bad_len
      $error("LEN_W too narrow for unit sizes");
   end

   logic [SUM_W-1:0] unit;
   logic [SUM_W-1:0] offs;
   logic [SUM_W-1:0] span;

   always_comb begin
      unit = is_cfg_i ? SUM_W'(CFG_UNIT) : SUM_W'(MEM_UNIT);
      offs = SUM_W'(addr_i) & (unit - 1'b1);
      span = offs + SUM_W'(len_i);
      abort_o = vld_i && (len_i != '0) &&
                ((SUM_W'(len_i) > unit) || (span > unit));
   end

   a_r4_zero_len_legal: assert property (@(posedge clk) disable iff (!rst_n)
      (len_i == '0) |-> !abort_o);
   a_r5_idle_no_abort: assert property (@(posedge clk) disable iff (!rst_n)
      !vld_i |-> !abort_o);
endmodule

// File: rtl/sts_w1c_bit.sv
module sts_w1c_bit #(
   parameter int unsigned TAG = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic q_o
);
   always_ff @(posedge clk) begin
      if (!rst_n)      q_o <= 1'b0;
      else if (set_i)  q_o <= 1'b1;
      else if (clr_i)  q_o <= 1'b0;
   end

   a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> q_o);
   a_r6_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !set_i) |=> !q_o);
   a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_i && !set_i) |=> $stable(q_o));
endmodule

// File: rtl/sts_cfg_port.sv
module sts_cfg_port #(
   parameter int unsigned CADDR_W = 12
) (
   input  logic                                  clk,
   input  logic                                  rst_n,
   input  logic                                  wr_i,
   input  logic                                  rd_i,
   input  logic [CADDR_W-1:0]                    addr_i,
   input  logic [cfg_status_pkg::BE_W-1:0]       be_i,
   input  logic [cfg_status_pkg::DW_W-1:0]       wdata_i,
   input  logic [cfg_status_pkg::STS_W-1:0]      sts_i,
   output logic [cfg_status_pkg::N_STICKY-1:0]   clr_o,
   output logic [cfg_status_pkg::DW_W-1:0]       rdata_o
);
   import cfg_status_pkg::*;

   localparam int unsigned DW_IDX = STS_OFFSET / BE_W;
   localparam int unsigned SH     = 8 * STS_LANE;

   if (CADDR_W < 3) begin : g_bad_w
      $error("CADDR_W too narrow to reach the status offset");
   end
   if (STS_LANE + STS_W / 8 > BE_W) begin : g_bad_lane
      $error("status word must not straddle a dword");
   end

   logic hit;
   assign hit = (addr_i[CADDR_W-1:2] == (CADDR_W-2)'(DW_IDX));

   for (genvar i = 0; i < N_STICKY; i++) begin : g_clr
      localparam int unsigned POS = sticky_pos(i);
      assign clr_o[i] = wr_i && hit && be_i[STS_LANE + POS/8] && wdata_i[SH + POS];
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         rdata_o <= '0;
      else if (rd_i)
         rdata_o <= hit ? (DW_W'(sts_i) << SH) : '0;
   end

   a_r9_fixed_fields: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_i && hit) |=> ((rdata_o[SH +: STS_W] & FIXED_MASK) == FIXED_VALUE));
   a_r10_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_i && !hit) |=> (rdata_o == '0));
endmodule

// File: rtl/cfg_status_unit.sv
module cfg_status_unit #(
   parameter int unsigned REQ_ADDR_W = 16,
   parameter int unsigned REQ_LEN_W  = 12,
   parameter int unsigned CADDR_W    = 12,
   parameter int unsigned MEM_UNIT   = 8,
   parameter int unsigned CFG_UNIT   = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [3:0]             err_ev_i,
   input  logic                   perr_resp_en_i,
   input  logic                   req_vld_i,
   input  logic                   req_is_cfg_i,
   input  logic [REQ_ADDR_W-1:0]  req_addr_i,
   input  logic [REQ_LEN_W-1:0]   req_len_i,
   input  logic                   cfg_wr_i,
   input  logic                   cfg_rd_i,
   input  logic [CADDR_W-1:0]     cfg_addr_i,
   input  logic [3:0]             cfg_be_i,
   input  logic [31:0]            cfg_wdata_i,
   output logic [31:0]            cfg_rdata_o
);
   import cfg_status_pkg::*;

   logic                abort;
   logic [N_STICKY-1:0] set_v;
   logic [N_STICKY-1:0] clr_v;
   logic [N_STICKY-1:0] q_v;
   logic [STS_W-1:0]    sts;

   sts_req_checker #(
      .ADDR_W  (REQ_ADDR_W),
      .LEN_W   (REQ_LEN_W),
      .MEM_UNIT(MEM_UNIT),
      .CFG_UNIT(CFG_UNIT)
   ) chk_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .vld_i   (req_vld_i),
      .is_cfg_i(req_is_cfg_i),
      .addr_i  (req_addr_i),
      .len_i   (req_len_i),
      .abort_o (abort)
   );

   always_comb begin
      set_v[SK_DPE]  = err_ev_i[EV_RX_DATA] | err_ev_i[EV_RX_ADDR];
      set_v[SK_STA]  = abort;
      set_v[SK_MDPE] = perr_resp_en_i & (err_ev_i[EV_POIS_CPL] | err_ev_i[EV_POIS_FWD]);
   end

   for (genvar i = 0; i < N_STICKY; i++) begin : g_sticky
      sts_w1c_bit #(.TAG(i)) bit_i (
         .clk  (clk),
         .rst_n(rst_n),
         .set_i(set_v[i]),
         .clr_i(clr_v[i]),
         .q_o  (q_v[i])
      );
   end

   always_comb begin
      sts = FIXED_VALUE;
      for (int i = 0; i < N_STICKY; i++) sts[sticky_pos(i)] = q_v[i];
   end

   sts_cfg_port #(.CADDR_W(CADDR_W)) port_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_i   (cfg_wr_i),
      .rd_i   (cfg_rd_i),
      .addr_i (cfg_addr_i),
      .be_i   (cfg_be_i),
      .wdata_i(cfg_wdata_i),
      .sts_i  (sts),
      .clr_o  (clr_v),
      .rdata_o(cfg_rdata_o)
   );

   a_r3_gated_by_enable: assert property (@(posedge clk) disable iff (!rst_n)
      !perr_resp_en_i |=> !$rose(q_v[SK_MDPE]));
   a_r2_detect_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (err_ev_i[EV_RX_DATA] || err_ev_i[EV_RX_ADDR]) |=> q_v[SK_DPE]);
endmodule

// File: tb/cfg_status_unit_tb_top.sv
module cfg_status_unit_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  err_ev = '0;
   logic        perr_en = 1'b0;
   logic        req_vld = 1'b0;
   logic        req_cfg = 1'b0;
   logic [15:0] req_addr = '0;
   logic [11:0] req_len = '0;
   logic        cfg_wr = 1'b0;
   logic        cfg_rd = 1'b0;
   logic [11:0] cfg_addr = '0;
   logic [3:0]  cfg_be = '0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;

   int n_checks = 0;
   int n_errors = 0;
   logic [31:0] exp_q[$];
   string       tag_q[$];
   logic        rd_seen = 1'b0;
   bit          done = 1'b0;

   always #10 clk = ~clk;

   cfg_status_unit dut_i (
      .clk(clk), .rst_n(rst_n), .err_ev_i(err_ev), .perr_resp_en_i(perr_en),
      .req_vld_i(req_vld), .req_is_cfg_i(req_cfg), .req_addr_i(req_addr),
      .req_len_i(req_len), .cfg_wr_i(cfg_wr), .cfg_rd_i(cfg_rd),
      .cfg_addr_i(cfg_addr), .cfg_be_i(cfg_be), .cfg_wdata_i(cfg_wdata),
      .cfg_rdata_o(cfg_rdata)
   );

   always @(posedge clk) rd_seen <= cfg_rd;

   // monitor: compare each read result against the scoreboard
   initial begin
      forever begin
         @(negedge clk);
         if (rd_seen && exp_q.size() > 0) begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_checks++;
            if (cfg_rdata !== e) begin
               n_errors++;
               $display("FAIL %s: got %08h expected %08h", t, cfg_rdata, e);
            end
         end
      end
   end

   task automatic rd(input logic [11:0] a, input logic [31:0] e, input string t);
      @(negedge clk);
      cfg_rd = 1'b1; cfg_addr = a;
      exp_q.push_back(e); tag_q.push_back(t);
      @(negedge clk);
      cfg_rd = 1'b0;
   endtask

   task automatic rd_sts(input logic [15:0] e, input string t);
      rd(12'h004, {e, 16'h0000}, t);
   endtask

   task automatic wr_ev(input logic [11:0] a, input logic [3:0] be,
                        input logic [31:0] d, input logic [3:0] ev);
      @(negedge clk);
      cfg_wr = 1'b1; cfg_addr = a; cfg_be = be; cfg_wdata = d; err_ev = ev;
      @(negedge clk);
      cfg_wr = 1'b0; err_ev = '0; cfg_be = '0; cfg_wdata = '0;
   endtask

   task automatic wr(input logic [11:0] a, input logic [3:0] be, input logic [31:0] d);
      wr_ev(a, be, d, 4'h0);
   endtask

   task automatic clear_all();
      wr(12'h004, 4'hF, 32'hFFFF_FFFF);
   endtask

   task automatic ev(input logic [3:0] m, input logic en);
      @(negedge clk);
      err_ev = m; perr_en = en;
      @(negedge clk);
      err_ev = '0; perr_en = 1'b0;
   endtask

   task automatic req(input logic c, input logic [15:0] a, input logic [11:0] l);
      @(negedge clk);
      req_vld = 1'b1; req_cfg = c; req_addr = a; req_len = l;
      @(negedge clk);
      req_vld = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      rd_sts(16'h0010, "R1 reset value");
      rd(12'h000, 32'h0, "R10 other dword reads zero");

      ev(4'b0001, 1'b0); rd_sts(16'h8010, "R2 data error, enable low");
      wr(12'h004, 4'h8, 32'h8000_0000); rd_sts(16'h0010, "R6 clear bit15");
      ev(4'b0010, 1'b1); rd_sts(16'h8010, "R2 addr parity");
      clear_all();

      ev(4'b0100, 1'b0); ev(4'b1000, 1'b0); rd_sts(16'h0010, "R3 poison ignored when disabled");
      ev(4'b0100, 1'b1); rd_sts(16'h0110, "R3 poisoned completion");
      wr(12'h004, 4'h8, 32'h0100_0000); rd_sts(16'h0010, "R6 clear bit8");
      ev(4'b1000, 1'b1); rd_sts(16'h0110, "R3 poisoned forward");
      clear_all();

      req(1'b0, 16'h0000, 12'd8); req(1'b0, 16'h0004, 12'd4);
      req(1'b0, 16'h0007, 12'd0); req(1'b0, 16'h0010, 12'd1);
      rd_sts(16'h0010, "R4 legal memory requests");
      req(1'b0, 16'h0005, 12'd4); rd_sts(16'h0810, "R4 memory crosses 8-byte unit");
      clear_all();
      req(1'b0, 16'h0000, 12'd9); rd_sts(16'h0810, "R4 memory longer than 8");
      clear_all();
      req(1'b1, 16'h0000, 12'd4); req(1'b1, 16'h0001, 12'd3); req(1'b1, 16'h0003, 12'd0);
      rd_sts(16'h0010, "R5 legal config requests");
      req(1'b1, 16'h0002, 12'd4); rd_sts(16'h0810, "R5 config crosses 4-byte unit");
      clear_all();
      req(1'b1, 16'h0000, 12'd8); rd_sts(16'h0810, "R5 config longer than 4");
      clear_all();

      ev(4'b0001, 1'b0); req(1'b0, 16'h0006, 12'd4);
      wr(12'h004, 4'hF, 32'h0000_0000); rd_sts(16'h8810, "R6 write zero keeps bits");
      wr(12'h004, 4'h8, 32'h0800_0000); rd_sts(16'h8010, "R6 clear only bit11");
      clear_all();

      ev(4'b0101, 1'b1); req(1'b1, 16'h0003, 12'd2);
      wr(12'h004, 4'h4, 32'hFFFF_FFFF); rd_sts(16'h8910, "R8 lane 2 only clears nothing");
      wr(12'h004, 4'h3, 32'hFFFF_FFFF); rd_sts(16'h8910, "R8 low lanes clear nothing");
      wr(12'h000, 4'hF, 32'hFFFF_FFFF); rd_sts(16'h8910, "R10 write elsewhere ignored");
      wr(12'h004, 4'h8, 32'hFFFF_FFFF); rd_sts(16'h0010, "R8 lane 3 clears");

      wr_ev(12'h004, 4'h8, 32'h8000_0000, 4'b0001); rd_sts(16'h8010, "R7 set wins over clear");
      clear_all();

      wr(12'h004, 4'hF, 32'hFFFF_FFFF); rd_sts(16'h0010, "R9 read-only fields ignore ones");
      wr(12'h004, 4'hF, 32'h0000_0000); rd_sts(16'h0010, "R9 read-only fields ignore zeros");

      repeat (3) @(negedge clk);
      done = 1'b1;
   end

   initial begin
      int cyc;
      cyc = 0;
      while (!done && cyc < 200000) begin
         @(posedge clk);
         cyc++;
      end
      if (!done) begin
         n_checks++; n_errors++;
         $display("FAIL watchdog: got timeout expected completion");
      end
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end
endmodule